// File: doc/BRIEF.md
# DRAM Device Power State Manager

This block keeps the power state of a single device on a packet-based DRAM channel. The device is in one of four states: active attention, standby, nap and power-down. Decoded row-packet operations move it between the two awake states. They also send it into one of the two sleep states. A wake-up indication, addressed by a separate powerdown-device number, brings it back out of sleep. After a programmable, scaled exit delay, the device returns to whichever awake state it held before it went to sleep.

Two lockout counters guard the sleep states. One sets a minimum dwell after sleep entry, and no exit is accepted until it has run out. The other sets a minimum awake time after an exit, and no new sleep request is accepted until it has run out. A request that breaks a lockout is ignored and raises a sticky error flag. While the device sleeps, row packets addressed to it have no effect, and the packet-accept output is low.

Top module: `dram_pwr_mgr`

## Requirements
- R1: After reset, state_o is standby (encoding ATTN=0, STBY=1, NAP=2, PDN=3), accept_o is 1, and err_entry_o and err_exit_o are 0.
- R2: A valid, non-broadcast row packet with op 0 (activate) and row_dev_i equal to dev_id_i moves standby to attention at the next clock edge. The same op with the broadcast flag set, or sent to another device, leaves the state unchanged.
- R3: A valid row packet with op 1 (relax), sent to this device or broadcast, moves attention to standby at the next clock edge. A relax sent to another device has no effect.
- R4: In an awake state, a valid row packet with op 2 (nap request) or op 3 (powerdown request), sent to this device or broadcast, enters NAP or PDN at the next edge. accept_o is 0 while the device is in NAP or PDN.
- R5: While the device sleeps, row packets addressed to it leave the state unchanged.
- R6: A wake-up pulse whose wake_dev_i equals pdev_id_i ends sleep, and the device returns to the awake state it held just before entry. A wake-up with any other address is ignored.
- R7: A wake-up accepted at clock edge k changes the state at edge k+nap_scale_i+1 when leaving NAP, and at edge k+pdn_scale_i+1 when leaving PDN.
- R8: Sleep entry loads a dwell count (nap_dwell_i or pdn_dwell_i), which counts down one per clock. A matching wake-up that arrives while the count is nonzero is ignored and sets err_exit_o.
- R9: Sleep exit loads a re-entry count (nap_reentry_i or pdn_reentry_i), which counts down one per clock. A sleep request that arrives while the count is nonzero is ignored and sets err_entry_o.
- R10: err_entry_o and err_exit_o stay set until reset, and reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dev_id_i | input | DEV_W | Device number matched by row packets |
| pdev_id_i | input | DEV_W | Powerdown-device number matched by wake-ups |
| row_vld_i | input | 1 | Row packet valid |
| row_op_i | input | 2 | Row op: 0 activate, 1 relax, 2 nap request, 3 powerdown request |
| row_dev_i | input | DEV_W | Row packet device number |
| row_bcast_i | input | 1 | Row packet is broadcast |
| wake_i | input | 1 | Wake-up sequence received |
| wake_dev_i | input | DEV_W | Device number carried by the wake-up |
| nap_reentry_i | input | CNT_W | Lockout after NAP exit, in cycles |
| nap_dwell_i | input | CNT_W | Minimum NAP dwell, in cycles |
| pdn_reentry_i | input | CNT_W | Lockout after PDN exit, in cycles |
| pdn_dwell_i | input | CNT_W | Minimum PDN dwell, in cycles |
| nap_scale_i | input | XS_W | NAP exit delay, in cycles |
| pdn_scale_i | input | XS_W | PDN exit delay, in cycles |
| state_o | output | 2 | Current power state |
| accept_o | output | 1 | Device accepts row and column packets |
| err_entry_o | output | 1 | Sticky: sleep request during re-entry lockout |
| err_exit_o | output | 1 | Sticky: wake-up during dwell lockout |

## Verification
The assertions take for granted that the row op field carries one operation per cycle, so a nap request and a powerdown request never arrive together. They also assume that the configuration inputs stay constant while a lockout or exit count runs. The stimulus holds every configuration input fixed for the whole run. It drives at most one row packet or one wake-up per cycle, each for a single cycle on the falling edge. Before each legal request it waits longer than the largest programmed lockout, so only the deliberate violation tests hit a running counter.

// File: rtl/dram_pwr_pkg.sv
package dram_pwr_pkg;
  typedef enum logic [1:0] {
    ST_ATTN = 2'd0,
    ST_STBY = 2'd1,
    ST_NAP  = 2'd2,
    ST_PDN  = 2'd3
  } pwr_state_t;

  typedef enum logic [1:0] {
    OP_ACT  = 2'd0,
    OP_RLX  = 2'd1,
    OP_NAPR = 2'd2,
    OP_PDNR = 2'd3
  } row_op_t;
endpackage

// File: rtl/dpm_lock_ctr.sv
module dpm_lock_ctr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R8/R9: one step down per clock while running
  a_r8_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dpm_row_decode.sv
module dpm_row_decode
  import dram_pwr_pkg::*;
#(
  parameter int DEV_W = 5
) (
  input  logic             vld_i,
  input  logic [1:0]       op_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic             bcast_i,
  input  logic [DEV_W-1:0] my_dev_i,
  output logic             act_o,
  output logic             rlx_o,
  output logic             nap_o,
  output logic             pdn_o
);
  logic    hit_own, hit_any;
  row_op_t op;

  assign op      = row_op_t'(op_i);
  assign hit_own = vld_i && !bcast_i && (dev_i == my_dev_i);
  assign hit_any = vld_i && (bcast_i || (dev_i == my_dev_i));

  // activate only honoured when not broadcast
  assign act_o = hit_own && (op == OP_ACT);
  assign rlx_o = hit_any && (op == OP_RLX);
  assign nap_o = hit_any && (op == OP_NAPR);
  assign pdn_o = hit_any && (op == OP_PDNR);

  a_r4_one_op: assert final ($countones({act_o, rlx_o, nap_o, pdn_o}) <= 1);
endmodule

// File: rtl/dpm_fsm.sv
module dpm_fsm
  import dram_pwr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int XS_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             rlx_i,
  input  logic             nap_i,
  input  logic             pdn_i,
  input  logic             wake_hit_i,
  input  logic             dw_zero_i,
  input  logic             ren_zero_i,
  input  logic             xd_zero_i,
  input  logic [CNT_W-1:0] nap_reentry_i,
  input  logic [CNT_W-1:0] nap_dwell_i,
  input  logic [CNT_W-1:0] pdn_reentry_i,
  input  logic [CNT_W-1:0] pdn_dwell_i,
  input  logic [XS_W-1:0]  nap_scale_i,
  input  logic [XS_W-1:0]  pdn_scale_i,
  output logic             dw_load_o,
  output logic [CNT_W-1:0] dw_val_o,
  output logic             ren_load_o,
  output logic [CNT_W-1:0] ren_val_o,
  output logic             xd_load_o,
  output logic [CNT_W-1:0] xd_val_o,
  output pwr_state_t       state_o,
  output logic             err_entry_o,
  output logic             err_exit_o
);
  localparam int PadW = CNT_W - XS_W;

  pwr_state_t state_q, state_d, saved_q;
  logic       exit_q, asleep;
  logic       entry_req, entry_ok, wake_req, wake_ok, exit_now;
  logic       err_entry_q, err_exit_q;

  assign asleep    = (state_q == ST_NAP) || (state_q == ST_PDN);
  assign entry_req = (nap_i || pdn_i) && !asleep;
  assign entry_ok  = entry_req && ren_zero_i;
  assign wake_req  = wake_hit_i && asleep && !exit_q;
  assign wake_ok   = wake_req && dw_zero_i;
  assign exit_now  = exit_q && xd_zero_i;

  always_comb begin
    state_d = state_q;
    if (exit_now)                           state_d = saved_q;
    else if (entry_ok)                      state_d = nap_i ? ST_NAP : ST_PDN;
    else if (act_i && state_q == ST_STBY)   state_d = ST_ATTN;
    else if (rlx_i && state_q == ST_ATTN)   state_d = ST_STBY;
  end

  assign dw_load_o  = entry_ok;
  assign dw_val_o   = nap_i ? nap_dwell_i : pdn_dwell_i;
  assign ren_load_o = exit_now;
  assign ren_val_o  = (state_q == ST_NAP) ? nap_reentry_i : pdn_reentry_i;
  assign xd_load_o  = wake_ok;
  assign xd_val_o   = (state_q == ST_NAP) ? {{PadW{1'b0}}, nap_scale_i}
                                          : {{PadW{1'b0}}, pdn_scale_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_STBY;
      saved_q     <= ST_STBY;
      exit_q      <= 1'b0;
      err_entry_q <= 1'b0;
      err_exit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (entry_ok) saved_q <= state_q;
      if (wake_ok)       exit_q <= 1'b1;
      else if (exit_now) exit_q <= 1'b0;
      if (entry_req && !ren_zero_i) err_entry_q <= 1'b1;
      if (wake_req && !dw_zero_i)   err_exit_q  <= 1'b1;
    end
  end

  assign state_o     = state_q;
  assign err_entry_o = err_entry_q;
  assign err_exit_o  = err_exit_q;

  a_r2_act_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STBY && act_i) |=> (state_q == ST_ATTN));
  a_r5_sleep_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep && !exit_q) |=> $stable(state_q));
  a_r6_exit_to_saved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_now |=> (state_q == $past(saved_q)));
  a_r8_no_early_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep && !dw_zero_i) |=> (state_q == ST_NAP || state_q == ST_PDN));
  a_r9_no_early_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!asleep && !ren_zero_i) |=> (state_q == ST_ATTN || state_q == ST_STBY));
  a_r10_entry_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_entry_q |=> err_entry_q);
  a_r10_exit_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_exit_q |=> err_exit_q);
endmodule

// File: rtl/dram_pwr_mgr.sv
module dram_pwr_mgr
  import dram_pwr_pkg::*;
#(
  parameter int DEV_W = 5,
  parameter int CNT_W = 8,
  parameter int XS_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEV_W-1:0] dev_id_i,
  input  logic [DEV_W-1:0] pdev_id_i,
  input  logic             row_vld_i,
  input  logic [1:0]       row_op_i,
  input  logic [DEV_W-1:0] row_dev_i,
  input  logic             row_bcast_i,
  input  logic             wake_i,
  input  logic [DEV_W-1:0] wake_dev_i,
  input  logic [CNT_W-1:0] nap_reentry_i,
  input  logic [CNT_W-1:0] nap_dwell_i,
  input  logic [CNT_W-1:0] pdn_reentry_i,
  input  logic [CNT_W-1:0] pdn_dwell_i,
  input  logic [XS_W-1:0]  nap_scale_i,
  input  logic [XS_W-1:0]  pdn_scale_i,
  output logic [1:0]       state_o,
  output logic             accept_o,
  output logic             err_entry_o,
  output logic             err_exit_o
);
  logic             act, rlx, nap, pdn, wake_hit;
  logic             dw_load, ren_load, xd_load;
  logic [CNT_W-1:0] dw_val, ren_val, xd_val;
  logic             dw_zero, ren_zero, xd_zero;
  pwr_state_t       state;

  assign wake_hit = wake_i && (wake_dev_i == pdev_id_i);

  dpm_row_decode #(.DEV_W(DEV_W)) u_dec (
    .vld_i(row_vld_i), .op_i(row_op_i), .dev_i(row_dev_i),
    .bcast_i(row_bcast_i), .my_dev_i(dev_id_i),
    .act_o(act), .rlx_o(rlx), .nap_o(nap), .pdn_o(pdn)
  );

  dpm_lock_ctr #(.W(CNT_W)) u_dwell (
    .clk_i, .rst_ni, .load_i(dw_load), .val_i(dw_val), .zero_o(dw_zero)
  );
  dpm_lock_ctr #(.W(CNT_W)) u_reentry (
    .clk_i, .rst_ni, .load_i(ren_load), .val_i(ren_val), .zero_o(ren_zero)
  );
  dpm_lock_ctr #(.W(CNT_W)) u_exit_dly (
    .clk_i, .rst_ni, .load_i(xd_load), .val_i(xd_val), .zero_o(xd_zero)
  );

  dpm_fsm #(.CNT_W(CNT_W), .XS_W(XS_W)) u_fsm (
    .clk_i, .rst_ni,
    .act_i(act), .rlx_i(rlx), .nap_i(nap), .pdn_i(pdn),
    .wake_hit_i(wake_hit),
    .dw_zero_i(dw_zero), .ren_zero_i(ren_zero), .xd_zero_i(xd_zero),
    .nap_reentry_i, .nap_dwell_i, .pdn_reentry_i, .pdn_dwell_i,
    .nap_scale_i, .pdn_scale_i,
    .dw_load_o(dw_load), .dw_val_o(dw_val),
    .ren_load_o(ren_load), .ren_val_o(ren_val),
    .xd_load_o(xd_load), .xd_val_o(xd_val),
    .state_o(state), .err_entry_o, .err_exit_o
  );

  assign state_o  = state;
  assign accept_o = (state == ST_ATTN) || (state == ST_STBY);

  // R4: sleeping device never accepts packets
  a_r4_no_accept_asleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o[1]) |-> !accept_o);
endmodule

// File: tb/dram_pwr_mgr_tb.sv
module dram_pwr_mgr_tb;
  localparam int DEV_W = 5, CNT_W = 8, XS_W = 4;
  localparam int MY = 3, PD = 9, NAPX = 2, PDNX = 3;
  localparam logic [1:0] ATTN = 2'd0, STBY = 2'd1, NAP = 2'd2, PDN = 2'd3;
  localparam logic [1:0] ACT = 2'd0, RLX = 2'd1, NAPR = 2'd2, PDNR = 2'd3;

  logic             clk = 1'b0, rst_n = 1'b0;
  logic             row_vld = 1'b0, row_bc = 1'b0, wake = 1'b0;
  logic [1:0]       row_op = '0;
  logic [DEV_W-1:0] row_dev = '0, wake_dev = '0;
  logic [1:0]       state;
  logic             accept, err_en, err_ex;
  int               checks = 0, errors = 0;
  bit               done = 1'b0;

  always #10 clk = ~clk;

  dram_pwr_mgr #(.DEV_W(DEV_W), .CNT_W(CNT_W), .XS_W(XS_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .dev_id_i(DEV_W'(MY)), .pdev_id_i(DEV_W'(PD)),
    .row_vld_i(row_vld), .row_op_i(row_op), .row_dev_i(row_dev),
    .row_bcast_i(row_bc), .wake_i(wake), .wake_dev_i(wake_dev),
    .nap_reentry_i(8'd4), .nap_dwell_i(8'd5),
    .pdn_reentry_i(8'd6), .pdn_dwell_i(8'd7),
    .nap_scale_i(4'(NAPX)), .pdn_scale_i(4'(PDNX)),
    .state_o(state), .accept_o(accept),
    .err_entry_o(err_en), .err_exit_o(err_ex)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic row(input logic [1:0] op, input int dev, input logic bc);
    @(negedge clk);
    row_vld = 1'b1; row_op = op; row_dev = DEV_W'(dev); row_bc = bc;
    @(negedge clk);
    row_vld = 1'b0; row_bc = 1'b0;
  endtask

  task automatic wake_up(input int dev);
    @(negedge clk);
    wake = 1'b1; wake_dev = DEV_W'(dev);
    @(negedge clk);
    wake = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    idle(2); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 state", state, STBY);
    check("R1 accept", accept, 1);
    check("R1 err_entry", err_en, 0);
    check("R1 err_exit", err_ex, 0);
  endtask

  task automatic t_act_relax();
    row(ACT, 5, 1'b0);   check("R2 other dev act", state, STBY);
    row(ACT, MY, 1'b1);  check("R2 broadcast act", state, STBY);
    row(ACT, MY, 1'b0);  check("R2 act", state, ATTN);
    row(RLX, 4, 1'b0);   check("R3 other dev relax", state, ATTN);
    row(RLX, 0, 1'b1);   check("R3 broadcast relax", state, STBY);
    row(ACT, MY, 1'b0);  check("R2 act again", state, ATTN);
  endtask

  task automatic t_nap_from_attn();
    row(NAPR, MY, 1'b0);
    check("R4 nap entry", state, NAP);
    check("R4 accept low", accept, 0);
    idle(10);
    row(ACT, MY, 1'b0);  check("R5 act ignored asleep", state, NAP);
    row(RLX, MY, 1'b0);  check("R5 relax ignored asleep", state, NAP);
    wake_up(MY); idle(5);
    check("R6 wrong wake address", state, NAP);
    wake_up(PD); idle(NAPX);
    check("R7 nap exit not early", state, NAP);
    idle(1);
    check("R7 nap exit time", state, ATTN);
    check("R6 back to attn", accept, 1);
  endtask

  task automatic t_pdn_from_stby();
    idle(10);
    row(RLX, MY, 1'b0);  check("R3 relax", state, STBY);
    row(PDNR, MY, 1'b0); check("R4 pdn entry", state, PDN);
    idle(10);
    wake_up(PD); idle(PDNX);
    check("R7 pdn exit not early", state, PDN);
    idle(1);
    check("R7 pdn exit time", state, STBY);
    check("R9 no false entry err", err_en, 0);
    check("R8 no false exit err", err_ex, 0);
    idle(10);
    row(NAPR, 0, 1'b1);  check("R4 broadcast nap", state, NAP);
    idle(10);
    wake_up(PD); idle(5);
    check("R6 back to stby", state, STBY);
  endtask

  task automatic t_dwell_err();
    idle(10);
    row(NAPR, MY, 1'b0); check("R4 nap entry", state, NAP);
    wake_up(PD);
    check("R8 early wake ignored", state, NAP);
    check("R8 exit err set", err_ex, 1);
    idle(4);
    check("R8 still asleep", state, NAP);
    idle(10);
    wake_up(PD); idle(NAPX + 1);
    check("R8 later wake exits", state, STBY);
  endtask

  task automatic t_reentry_err();
    row(PDNR, MY, 1'b0);
    check("R9 early entry ignored", state, STBY);
    check("R9 entry err set", err_en, 1);
    idle(10);
    row(PDNR, MY, 1'b0); check("R9 later entry ok", state, PDN);
    idle(10);
    wake_up(PD); idle(5);
    check("R6 pdn exit stby", state, STBY);
  endtask

  task automatic t_sticky();
    idle(5);
    check("R10 entry err held", err_en, 1);
    check("R10 exit err held", err_ex, 1);
    do_reset();
    check("R10 entry err cleared", err_en, 0);
    check("R10 exit err cleared", err_ex, 0);
    check("R1 state after reset", state, STBY);
  endtask

  initial begin
    t_reset();
    t_act_relax();
    t_nap_from_attn();
    t_pdn_from_stby();
    t_dwell_err();
    t_reentry_err();
    t_sticky();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule